// File: doc/BRIEF.md
# Serial Byte Link with Switchable Flow Control

This block is an 8N1 serial transmitter and receiver. Each byte goes out least-significant bit first, framed by a low start bit and a high stop bit, and the line idles high. Every bit lasts a programmable number of core-clock cycles. A run-time mode input selects how the link regulates traffic:

- a request/clear-to-send pin pair;
- a terminal-ready/set-ready pin pair;
- in-band pause and resume characters;
- no flow control at all;
- an off state, in which the serial pins act as plain general-purpose I/O.

Bytes to send arrive on a valid/ready input and wait in a single holding register. Received bytes go into a holding register and are read out one at a time. A second staged register behind it keeps one more byte while the holding register is full. The flow-control inputs are looked at only between frames, so a character that has started on the line always completes. In the in-band mode, the characters that pause and resume the transmitter are consumed and never reach the byte output. The block sends its own pause character when the holding register fills and its own resume character when that register drains, and these two characters go ahead of queued data.

Top module: `uart_fc`

## Requirements
- R1: After reset, tx_o is high, tx_ready_o is high, rx_valid_o is low and rts_no is low, in every mode except off.
- R2: A byte accepted on tx_valid_i/tx_ready_o is sent on tx_o as one low start bit, then data bits 0 to 7, then one high stop bit. Each bit lasts exactly baud_div_i cycles. While a byte waits in the holding register, tx_ready_o is low.
- R3: A frame on rx_i with a high stop bit appears on rx_data_o with rx_valid_o high no later than one cycle after the end of its stop bit. Each bit is sampled at mid-period, counted from the detected start edge.
- R4: Received bytes are kept in arrival order in the holding register and one staged register behind it. A pulse on rx_read_i while rx_valid_o is high pops one byte. A byte that arrives while both registers are full is dropped.
- R5: In mode 1, rts_no is high exactly while both the holding register and the staged register are full, and low otherwise.
- R6: In mode 1, a frame starts only when the synchronized cts_ni is low at a frame boundary. Raising cts_ni during a frame does not cut that frame short.
- R7: In mode 2, a frame starts only when the synchronized dsr_ni is low at a frame boundary.
- R8: dtr_no comes out of reset low (asserted). A cycle with dtr_we_i high loads dtr_no with the inverse of dtr_wdata_i. dtr_no holds its value otherwise.
- R9: In mode 3, receiving xoff_char_i pauses data transmission after the current frame, and receiving xon_char_i resumes it. Neither character is presented on rx_data_o.
- R10: In mode 3, the block sends xoff_char_i when the receive holding register goes from empty to full, and xon_char_i when it goes from full to empty. These characters go ahead of queued data and are sent even while paused.
- R11: In mode 0 (off), tx_o follows gpio_out_i[0] and rts_no follows gpio_out_i[1]. gpio_in_o returns {cts, rx} after two synchronizer stages. tx_ready_o is low and frames on rx_i are ignored.
- R12: In mode 4 (and any unused code), cts_ni and dsr_ni have no effect on transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | 0 off, 1 RTS/CTS, 2 DTR/DSR, 3 in-band, 4 none |
| baud_div_i | input | DIV_W | Core cycles per bit, 4 or more |
| xon_char_i | input | 8 | Resume character (typically 0x11) |
| xoff_char_i | input | 8 | Pause character (typically 0x13) |
| dtr_we_i | input | 1 | Load strobe for the terminal-ready level |
| dtr_wdata_i | input | 1 | 1 asserts terminal-ready |
| gpio_out_i | input | 2 | Off mode: bit0 drives tx_o, bit1 drives rts_no |
| gpio_in_o | output | 2 | Synchronized {cts_ni, rx_i} |
| tx_data_i | input | 8 | Byte to send |
| tx_valid_i | input | 1 | tx_data_i is valid |
| tx_ready_o | output | 1 | Transmit holding register is free |
| rx_data_o | output | 8 | Oldest received byte |
| rx_valid_o | output | 1 | rx_data_o holds a byte |
| rx_read_i | input | 1 | Pops the oldest received byte |
| tx_o | output | 1 | Serial output |
| rx_i | input | 1 | Serial input |
| rts_no | output | 1 | Ready-to-receive, active low |
| cts_ni | input | 1 | Peer ready, active low |
| dtr_no | output | 1 | Terminal ready, active low |
| dsr_ni | input | 1 | Peer set ready, active low |

## Verification
A transmit frame starts one cycle after its byte is accepted, and the start bit lasts baud_div_i cycles. The bench decodes tx_o at each bit centre, half a cycle plus baud_div_i/2 after it sees the falling edge. A received byte is due within one cycle after the stop bit that the bench drives, so the bench checks rx_valid_o one clock after its serializer finishes. Control characters and gated bytes are checked against a window of more than one frame, and their absence is checked after several frames. Synchronized GPIO inputs are checked three cycles after they change, which covers the two flop stages.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;
  localparam int BYTE_W  = 8;
  localparam int FRAME_W = BYTE_W + 2;

  typedef enum logic [2:0] {
    FC_OFF    = 3'd0,
    FC_RTSCTS = 3'd1,
    FC_DTRDSR = 3'd2,
    FC_INBAND = 3'd3,
    FC_NONE   = 3'd4
  } fc_mode_e;
endpackage

// File: rtl/uart_fc_sync.sv
module uart_fc_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/uart_fc_tx.sv
module uart_fc_tx
  import uart_fc_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              busy_o,
  output logic              txd_o
);
  localparam int IDX_W = $clog2(FRAME_W);

  logic               busy_q;
  logic [DIV_W-1:0]   cnt_q;
  logic [IDX_W-1:0]   idx_q;
  logic [FRAME_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '1;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        sh_q   <= {1'b1, data_i, 1'b0};
        cnt_q  <= '0;
        idx_q  <= '0;
      end
    end else if (cnt_q == div_i - DIV_W'(1)) begin
      cnt_q <= '0;
      sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
      if (idx_q == IDX_W'(FRAME_W - 1)) busy_q <= 1'b0;
      else                              idx_q  <= idx_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign txd_o  = busy_q ? sh_q[0] : 1'b1;
endmodule

// File: rtl/uart_fc_rx.sv
module uart_fc_rx
  import uart_fc_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              en_i,
  input  logic              rxd_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              stb_o
);
  localparam int BIT_W = $clog2(BYTE_W);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_e;

  rx_st_e            st_q;
  logic [DIV_W-1:0]  cnt_q;
  logic [BIT_W-1:0]  idx_q;
  logic [BYTE_W-1:0] sh_q;
  logic [DIV_W-1:0]  half;
  logic              at_end;

  assign half   = div_i >> 1;
  assign at_end = (cnt_q == div_i - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      byte_o <= '0;
      stb_o  <= 1'b0;
    end else begin
      stb_o <= 1'b0;
      if (!en_i) begin
        st_q <= RX_IDLE;
      end else begin
        unique case (st_q)
          RX_IDLE: if (!rxd_i) begin
            st_q  <= RX_START;
            cnt_q <= '0;
          end
          RX_START: begin
            if (cnt_q == half - DIV_W'(1)) begin
              cnt_q <= '0;
              idx_q <= '0;
              st_q  <= rxd_i ? RX_IDLE : RX_DATA;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_DATA: begin
            if (at_end) begin
              cnt_q <= '0;
              sh_q  <= {rxd_i, sh_q[BYTE_W-1:1]};
              if (idx_q == BIT_W'(BYTE_W - 1)) st_q  <= RX_STOP;
              else                             idx_q <= idx_q + 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_STOP: begin
            if (at_end) begin
              cnt_q <= '0;
              st_q  <= RX_IDLE;
              if (rxd_i) begin
                byte_o <= sh_q;
                stb_o  <= 1'b1;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: st_q <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_fc.sv
module uart_fc
  import uart_fc_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mode_i,
  input  logic [DIV_W-1:0]  baud_div_i,
  input  logic [BYTE_W-1:0] xon_char_i,
  input  logic [BYTE_W-1:0] xoff_char_i,
  input  logic              dtr_we_i,
  input  logic              dtr_wdata_i,
  input  logic [1:0]        gpio_out_i,
  output logic [1:0]        gpio_in_o,
  input  logic [BYTE_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_read_i,
  output logic              tx_o,
  input  logic              rx_i,
  output logic              rts_no,
  input  logic              cts_ni,
  output logic              dtr_no,
  input  logic              dsr_ni
);
  logic is_off, is_rc, is_dd, is_ib;
  assign is_off = (mode_i == FC_OFF);
  assign is_rc  = (mode_i == FC_RTSCTS);
  assign is_dd  = (mode_i == FC_DTRDSR);
  assign is_ib  = (mode_i == FC_INBAND);

  // synchronizers: {dsr, cts, rx}
  logic [2:0] pins_s;
  logic       rx_s, cts_s, dsr_s;
  uart_fc_sync #(.W(3), .RST_VAL(3'b111)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({dsr_ni, cts_ni, rx_i}),
    .q_o (pins_s)
  );
  assign {dsr_s, cts_s, rx_s} = pins_s;
  assign gpio_in_o = {cts_s, rx_s};

  // terminal-ready level
  logic dtr_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       dtr_q <= 1'b1;
    else if (dtr_we_i) dtr_q <= dtr_wdata_i;
  end
  assign dtr_no = ~dtr_q;

  // receive path
  logic [BYTE_W-1:0] rx_byte;
  logic              rx_stb;
  uart_fc_rx #(.DIV_W(DIV_W)) u_rx (
    .clk_i, .rst_ni,
    .div_i  (baud_div_i),
    .en_i   (!is_off),
    .rxd_i  (rx_s),
    .byte_o (rx_byte),
    .stb_o  (rx_stb)
  );

  logic              is_xon_c, is_xoff_c, store;
  assign is_xoff_c = is_ib && (rx_byte == xoff_char_i);
  assign is_xon_c  = is_ib && (rx_byte == xon_char_i);
  assign store     = rx_stb && !is_xoff_c && !is_xon_c;

  logic              hold_full_q, stg_full_q;
  logic [BYTE_W-1:0] hold_q, stg_q;
  logic              hold_full_d, stg_full_d;
  logic [BYTE_W-1:0] hold_d, stg_d;
  logic              pop;
  assign pop = rx_read_i && hold_full_q;

  always_comb begin
    hold_full_d = hold_full_q;
    hold_d      = hold_q;
    stg_full_d  = stg_full_q;
    stg_d       = stg_q;
    if (pop) begin
      if (stg_full_d) begin
        hold_d     = stg_d;
        stg_full_d = 1'b0;
      end else begin
        hold_full_d = 1'b0;
      end
    end
    if (store) begin
      if (!hold_full_d) begin
        hold_full_d = 1'b1;
        hold_d      = rx_byte;
      end else if (!stg_full_d) begin
        stg_full_d = 1'b1;
        stg_d      = rx_byte;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_full_q <= 1'b0;
      stg_full_q  <= 1'b0;
      hold_q      <= '0;
      stg_q       <= '0;
    end else begin
      hold_full_q <= hold_full_d;
      stg_full_q  <= stg_full_d;
      hold_q      <= hold_d;
      stg_q       <= stg_d;
    end
  end

  assign rx_valid_o = hold_full_q;
  assign rx_data_o  = hold_q;

  // transmit path
  logic              tx_busy, tx_start, txd;
  logic [BYTE_W-1:0] tx_sel;
  logic              txh_full_q;
  logic [BYTE_W-1:0] txh_q;
  logic              paused_q, xoff_pend_q, xon_pend_q;
  logic              gate, send_xoff, send_xon, send_data;

  always_comb begin
    unique case (mode_i)
      FC_OFF:    gate = 1'b0;
      FC_RTSCTS: gate = !cts_s;
      FC_DTRDSR: gate = !dsr_s;
      FC_INBAND: gate = !paused_q;
      default:   gate = 1'b1;
    endcase
  end

  assign send_xoff = !tx_busy && is_ib && xoff_pend_q;
  assign send_xon  = !tx_busy && is_ib && !xoff_pend_q && xon_pend_q;
  assign send_data = !tx_busy && !send_xoff && !send_xon && txh_full_q && gate;
  assign tx_start  = send_xoff || send_xon || send_data;
  assign tx_sel    = send_xoff ? xoff_char_i : send_xon ? xon_char_i : txh_q;

  assign tx_ready_o = !txh_full_q && !is_off;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txh_full_q <= 1'b0;
      txh_q      <= '0;
    end else if (tx_valid_i && tx_ready_o) begin
      txh_full_q <= 1'b1;
      txh_q      <= tx_data_i;
    end else if (send_data) begin
      txh_full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      paused_q    <= 1'b0;
      xoff_pend_q <= 1'b0;
      xon_pend_q  <= 1'b0;
    end else if (!is_ib) begin
      paused_q    <= 1'b0;
      xoff_pend_q <= 1'b0;
      xon_pend_q  <= 1'b0;
    end else begin
      if (rx_stb && is_xoff_c)     paused_q <= 1'b1;
      else if (rx_stb && is_xon_c) paused_q <= 1'b0;
      if (!hold_full_q && hold_full_d) begin
        xoff_pend_q <= 1'b1;
        xon_pend_q  <= 1'b0;
      end else if (hold_full_q && !hold_full_d) begin
        xon_pend_q  <= 1'b1;
        xoff_pend_q <= 1'b0;
      end else begin
        if (send_xoff) xoff_pend_q <= 1'b0;
        if (send_xon)  xon_pend_q  <= 1'b0;
      end
    end
  end

  uart_fc_tx #(.DIV_W(DIV_W)) u_tx (
    .clk_i, .rst_ni,
    .div_i   (baud_div_i),
    .start_i (tx_start),
    .data_i  (tx_sel),
    .busy_o  (tx_busy),
    .txd_o   (txd)
  );

  assign tx_o   = is_off ? gpio_out_i[0] : txd;
  assign rts_no = is_off ? gpio_out_i[1] : (is_rc && hold_full_q && stg_full_q);

  logic unused_dd;
  assign unused_dd = is_dd;
endmodule

// File: rtl/uart_fc_chk.sv
module uart_fc_chk
  import uart_fc_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] mode_i,
  input logic       dtr_we_i,
  input logic       tx_valid_i,
  input logic       tx_ready_o,
  input logic [7:0] rx_data_o,
  input logic       rx_valid_o,
  input logic       rx_read_i,
  input logic       rts_no,
  input logic       dtr_no
);
  AST_TX_HOLD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && tx_ready_o) |=> !tx_ready_o);  // R2

  AST_RX_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rx_read_i) |=> (rx_valid_o && $stable(rx_data_o)));  // R4

  AST_RTS_EMPTY_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == FC_RTSCTS && !rx_valid_o) |-> !rts_no);  // R5

  AST_DTR_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dtr_we_i |=> $stable(dtr_no));  // R8

  AST_OFF_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == FC_OFF) |-> !tx_ready_o);  // R11
endmodule

bind uart_fc uart_fc_chk u_chk (.*);

// File: tb/uart_fc_tb.sv
module uart_fc_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode = 3'd4;
  logic [15:0] div = 16'd8;
  logic       dtr_we = 1'b0, dtr_wd = 1'b0;
  logic [1:0] gpo = 2'b01;
  logic [1:0] gpi;
  logic [7:0] txd = '0;
  logic       txv = 1'b0;
  logic       txr;
  logic [7:0] rxd;
  logic       rxv;
  logic       rxrd = 1'b0;
  logic       tx, rx = 1'b1, rts, cts = 1'b0, dtr, dsr = 1'b0;

  int n_chk = 0, n_fail = 0;
  int mon_cnt = 0, mon_ferr = 0;
  logic [7:0] mon_log [0:511];
  bit mon_en = 1'b1;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_fc u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .baud_div_i(div),
    .xon_char_i(8'h11), .xoff_char_i(8'h13),
    .dtr_we_i(dtr_we), .dtr_wdata_i(dtr_wd),
    .gpio_out_i(gpo), .gpio_in_o(gpi),
    .tx_data_i(txd), .tx_valid_i(txv), .tx_ready_o(txr),
    .rx_data_o(rxd), .rx_valid_o(rxv), .rx_read_i(rxrd),
    .tx_o(tx), .rx_i(rx), .rts_no(rts), .cts_ni(cts),
    .dtr_no(dtr), .dsr_ni(dsr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  // serial decoder on tx_o, samples at bit centres
  initial begin
    forever begin
      @(negedge clk);
      if (mon_en && tx === 1'b0) begin : frame
        int d;
        logic [7:0] b;
        d = int'(div);
        repeat (d / 2) @(negedge clk);
        if (tx !== 1'b0) mon_ferr++;
        for (int i = 0; i < 8; i++) begin
          repeat (d) @(negedge clk);
          b[i] = tx;
        end
        repeat (d) @(negedge clk);
        if (tx !== 1'b1) mon_ferr++;
        mon_log[mon_cnt] = b;
        mon_cnt++;
      end
    end
  end

  task automatic send_tx(input logic [7:0] b);
    int t = 0;
    @(negedge clk);
    while (!txr && t < 2000) begin
      @(negedge clk);
      t++;
    end
    txd = b;
    txv = 1'b1;
    @(negedge clk);
    txv = 1'b0;
  endtask

  task automatic send_rx(input logic [7:0] b);
    logic [9:0] f;
    f = {1'b1, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      rx = f[i];
      repeat (int'(div)) @(negedge clk);
    end
  endtask

  task automatic pop();
    rxrd = 1'b1;
    @(negedge clk);
    rxrd = 1'b0;
  endtask

  task automatic wait_cnt(input int target);
    int t = 0;
    while (mon_cnt < target && t < 40000) begin
      @(negedge clk);
      t++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    summary();
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, R8 asserted terminal-ready
    chk("R1 tx idle", tx, 1);
    chk("R1 tx_ready", txr, 1);
    chk("R1 rx_valid", rxv, 0);
    chk("R1 rts", rts, 0);
    chk("R8 dtr reset", dtr, 0);

    // R2 full byte sweep at div 8
    for (int b = 0; b < 256; b++) send_tx(8'(b));
    wait_cnt(256);
    repeat (20) @(negedge clk);
    chk("R2 count", mon_cnt, 256);
    for (int b = 0; b < 256; b++) chk("R2 byte", mon_log[b], b);
    // R2 odd divisor
    div = 16'd5;
    send_tx(8'hA5); send_tx(8'h01); send_tx(8'h80);
    wait_cnt(259);
    repeat (20) @(negedge clk);
    chk("R2 div5 a", mon_log[256], 8'hA5);
    chk("R2 div5 b", mon_log[257], 8'h01);
    chk("R2 div5 c", mon_log[258], 8'h80);
    chk("R2 frame err", mon_ferr, 0);
    div = 16'd8;

    // R3 receive sweep, byte due one cycle after stop bit
    for (int b = 0; b < 256; b++) begin
      send_rx(8'(b));
      @(negedge clk);
      chk("R3 valid", rxv, 1);
      chk("R3 data", rxd, b);
      pop();
      chk("R3 popped", rxv, 0);
    end

    // R4 order and overrun
    send_rx(8'h3C); send_rx(8'hC3); send_rx(8'h77);
    @(negedge clk);
    chk("R4 first", rxd, 8'h3C);
    pop();
    chk("R4 second valid", rxv, 1);
    chk("R4 second", rxd, 8'hC3);
    pop();
    chk("R4 third dropped", rxv, 0);

    // R5 rts from buffer fullness
    cts = 1'b1;
    mode = 3'd1;
    repeat (3) @(negedge clk);
    chk("R5 empty", rts, 0);
    send_rx(8'h01);
    @(negedge clk);
    chk("R5 one", rts, 0);
    send_rx(8'h02);
    @(negedge clk);
    chk("R5 two", rts, 1);
    pop();
    chk("R5 after pop", rts, 0);
    pop();

    // R6 cts gating
    base = mon_cnt;
    send_tx(8'h5A);
    repeat (300) @(negedge clk);
    chk("R6 held", mon_cnt, base);
    cts = 1'b0;
    repeat (120) @(negedge clk);
    chk("R6 released cnt", mon_cnt, base + 1);
    chk("R6 released byte", mon_log[base], 8'h5A);
    send_tx(8'h69);
    repeat (20) @(negedge clk);
    cts = 1'b1;
    repeat (100) @(negedge clk);
    chk("R6 midframe cnt", mon_cnt, base + 2);
    chk("R6 midframe byte", mon_log[base+1], 8'h69);
    chk("R6 frame err", mon_ferr, 0);

    // R7 dsr gating
    mode = 3'd2;
    dsr = 1'b1;
    base = mon_cnt;
    send_tx(8'hC6);
    repeat (300) @(negedge clk);
    chk("R7 held", mon_cnt, base);
    dsr = 1'b0;
    repeat (120) @(negedge clk);
    chk("R7 released", mon_cnt, base + 1);
    chk("R7 byte", mon_log[base], 8'hC6);

    // R12 no flow control ignores cts and dsr
    mode = 3'd4;
    cts = 1'b1;
    dsr = 1'b1;
    base = mon_cnt;
    send_tx(8'hE7);
    repeat (120) @(negedge clk);
    chk("R12 sent", mon_cnt, base + 1);
    chk("R12 byte", mon_log[base], 8'hE7);
    cts = 1'b0;
    dsr = 1'b0;

    // R8 terminal-ready control
    dtr_wd = 1'b0; dtr_we = 1'b1;
    @(negedge clk);
    dtr_we = 1'b0;
    chk("R8 deassert", dtr, 1);
    repeat (5) @(negedge clk);
    chk("R8 holds", dtr, 1);
    dtr_wd = 1'b1; dtr_we = 1'b1;
    @(negedge clk);
    dtr_we = 1'b0;
    chk("R8 assert", dtr, 0);

    // R9 in-band pause/resume from peer
    mode = 3'd3;
    base = mon_cnt;
    send_rx(8'h13);
    @(negedge clk);
    chk("R9 xoff consumed", rxv, 0);
    send_tx(8'h42);
    repeat (300) @(negedge clk);
    chk("R9 paused", mon_cnt, base);
    send_rx(8'h11);
    @(negedge clk);
    chk("R9 xon consumed", rxv, 0);
    repeat (120) @(negedge clk);
    chk("R9 resumed", mon_cnt, base + 1);
    chk("R9 byte", mon_log[base], 8'h42);

    // R10 own pause/resume chars, ahead of data and while paused
    send_rx(8'h13);
    send_tx(8'h55);
    base = mon_cnt;
    send_rx(8'h99);
    @(negedge clk);
    chk("R10 stored", rxd, 8'h99);
    repeat (120) @(negedge clk);
    chk("R10 xoff cnt", mon_cnt, base + 1);
    chk("R10 xoff char", mon_log[base], 8'h13);
    send_rx(8'h11);
    repeat (120) @(negedge clk);
    chk("R10 data after resume", mon_log[base+1], 8'h55);
    pop();
    repeat (120) @(negedge clk);
    chk("R10 xon cnt", mon_cnt, base + 3);
    chk("R10 xon char", mon_log[base+2], 8'h11);

    // R11 off mode as GPIO
    mon_en = 1'b0;
    gpo = 2'b01;
    mode = 3'd0;
    @(negedge clk);
    chk("R11 not ready", txr, 0);
    gpo = 2'b10;
    @(negedge clk);
    chk("R11 tx gpio", tx, 0);
    chk("R11 rts gpio", rts, 1);
    gpo = 2'b01;
    @(negedge clk);
    chk("R11 tx gpio hi", tx, 1);
    chk("R11 rts gpio lo", rts, 0);
    rx = 1'b0;
    cts = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 gpio in", gpi, 2'b10);
    rx = 1'b1;
    cts = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 gpio in back", gpi, 2'b01);
    send_rx(8'h12);
    repeat (2) @(negedge clk);
    chk("R11 rx ignored", rxv, 0);

    summary();
  end
endmodule